// File: doc/BRIEF.md
# SD Host Register Layout Translator

This block sits on the register bus between software that expects the standard SD host controller register map and a controller whose registers use a different vendor layout. Each access carries a byte offset in the standard map and a size: byte, halfword or word. The block redirects the access to the vendor word that holds the field. It moves bit fields between the two layouts. For sub-word writes it performs the read-modify-write that a backing store with only 32-bit access requires. The vendor registers live in an internal 32-bit register file. A second read-only port, the peek port, exposes any word of that file, so the translated contents can be observed directly.

A parameter selects one of two vendor layouts. The combined layout has a single 32-bit command-and-mode word. A transfer-mode write is held in a local cache. The command write then merges with that cache and stores the whole word in one write. The mixed layout keeps the transfer-mode bits in a separate mixed-control word and reports a fixed host version. Present-state and interrupt-status values come from the controller core through input pins. Every access takes two cycles after acceptance and ends with a one-cycle response pulse.

Top module: `sd_reg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every register-file word reads 0 through the peek port.
- R2: A byte write to offset 0x28 updates vendor word 0x28 as follows. Bits 2:1 become 2 when data bit 5 (8-bit bus) is set, whatever bit 1 holds. They become 1 when only data bit 1 (4-bit bus) is set, and 0 otherwise. Bit 0 and bits 7:6 copy data bits 0 and 7:6. Bits 9:8 take data bits 4:3. All other bits of the word keep their value.
- R3: A byte read of offset 0x28 returns the following. Bit 0 and bits 7:6 come from vendor bits 0 and 7:6. Bit 1 is set when vendor bits 2:1 equal 1, and bit 5 when they equal 2. Bits 4:3 read 2 when vendor bits 9:8 equal 2, and 3 when they equal 3. Otherwise bits 4:3 read 0.
- R4: A word read of offset 0x24 returns `hw_pstate` masked with 0x000F0F07, with vendor bits 27:24 placed at bits 23:20 and vendor bit 12 placed at bit 3.
- R5: Combined layout: a halfword write to 0x0C changes only the cached mode and leaves vendor word 0x0C unchanged. A halfword read of 0x0C returns the cached mode.
- R6: Combined layout: a halfword write to 0x0E stores {data, cached mode} into vendor word 0x0C in one write. A halfword read of 0x0E returns the cached command.
- R7: Mixed layout: a halfword write to 0x0C clears bits 5:0 of vendor word 0x48 and then ORs in the data masked with 0x37. A halfword read of 0x0C returns vendor word 0x48 masked with 0x37.
- R8: Mixed layout: a halfword read of 0xFE returns 0x0002. In the combined layout, offset 0xFE is an ordinary halfword.
- R9: A halfword read of 0xFC returns 1 when `hw_istat` AND vendor word 0x38 is nonzero, and 0 otherwise.
- R10: A byte read of 0x29 returns 0x0D. A byte write to 0x29 changes no register-file word.
- R11: Any other access maps to the word at the offset with bits 1:0 cleared. Offset bits 1:0 select the byte or halfword lane. Sub-word writes replace only that lane. Reads return the lane zero-extended. `req_size` 0 means byte, 1 means halfword, and 2 or 3 mean word.
- R12: An accepted request drops `req_ready` for one cycle. `rsp_valid` pulses for exactly one cycle, two cycles after acceptance, and in that same cycle `req_ready` is 1 again. Write responses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte offset in the standard map |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, zero-extended |
| hw_pstate | input | 32 | Vendor present-state value from the core |
| hw_istat | input | 32 | Interrupt status from the core |
| peek_idx | input | ADDR_W-2 | Register-file word index to observe |
| peek_data | output | 32 | Word at `peek_idx`, one cycle later |

## Verification
Two things can happen in the same cycle: the response of one access is emitted while the next request is accepted. The bench provokes this by holding `req_valid` high across two requests without a gap. The second request is a read of a word that the first request writes. It then judges three things: that the busy cycle, the response pulse and the second acceptance land exactly on the cycles R12 specifies, and that the read returns the freshly merged word. Register-file updates are also judged through the peek port, which reads the file in parallel with the request path.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  typedef enum logic {
    LAYOUT_COMBINED = 1'b0,
    LAYOUT_MIXED    = 1'b1
  } layout_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;

  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_HCTL   = 3'd1,
    K_PWR    = 3'd2,
    K_XMODE  = 3'd3,
    K_CMD    = 3'd4,
    K_PSTATE = 3'd5,
    K_SLOT   = 3'd6,
    K_VER    = 3'd7
  } kind_e;

  // standard-map byte offsets
  localparam logic [7:0] OFS_XMODE = 8'h0C;
  localparam logic [7:0] OFS_CMD   = 8'h0E;
  localparam logic [7:0] OFS_PSTAT = 8'h24;
  localparam logic [7:0] OFS_HCTL  = 8'h28;
  localparam logic [7:0] OFS_PWR   = 8'h29;
  localparam logic [7:0] OFS_SIGEN = 8'h38;
  localparam logic [7:0] OFS_MIX   = 8'h48;
  localparam logic [7:0] OFS_SLOT  = 8'hFC;
  localparam logic [7:0] OFS_VER   = 8'hFE;

  localparam logic [31:0] PWR_READ   = 32'h0000_000D;
  localparam logic [31:0] VER_READ   = 32'h0000_0002;
  localparam logic [31:0] XMODE_KEEP = 32'h0000_0037;
  localparam logic [31:0] XMODE_CLR  = 32'h0000_003F;
  localparam logic [31:0] HCTL_CLR   = 32'h0000_03C7;

  function automatic logic [31:0] hctl_pack(input logic [31:0] cur, input logic [7:0] v);
    logic [31:0] r;
    r      = cur & ~HCTL_CLR;
    r[0]   = v[0];
    r[2:1] = v[5] ? 2'd2 : (v[1] ? 2'd1 : 2'd0);
    r[7:6] = v[7:6];
    r[9:8] = v[4:3];
    return r;
  endfunction

  function automatic logic [7:0] hctl_unpack(input logic [31:0] w);
    logic [7:0] r;
    r      = 8'h00;
    r[0]   = w[0];
    r[7:6] = w[7:6];
    r[1]   = (w[2:1] == 2'd1);
    r[5]   = (w[2:1] == 2'd2);
    r[4]   = w[9];
    r[3]   = w[9] & w[8];
    return r;
  endfunction

  function automatic logic [31:0] pstate_std(input logic [31:0] p);
    return (p & 32'h000F_0F07) | ((p >> 4) & 32'h00F0_0000) | ((p >> 9) & 32'h0000_0008);
  endfunction

endpackage

// File: rtl/sdx_regfile.sv
module sdx_regfile #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] pk_addr,
  output logic [DW-1:0] pk_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
    pk_data <= mem[pk_addr];
  end
endmodule

// File: rtl/sdx_decode.sv
module sdx_decode
  import sdx_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_MIXED,
  parameter int      ADDR_W = 8
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic [ADDR_W-3:0] phys
);
  localparam logic [ADDR_W-1:0] A_XMODE = ADDR_W'(OFS_XMODE);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(OFS_PSTAT);
  localparam logic [ADDR_W-1:0] A_HCTL  = ADDR_W'(OFS_HCTL);
  localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(OFS_PWR);
  localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(OFS_SIGEN);
  localparam logic [ADDR_W-1:0] A_MIX   = ADDR_W'(OFS_MIX);
  localparam logic [ADDR_W-1:0] A_SLOT  = ADDR_W'(OFS_SLOT);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
  localparam bit MIXED = (LAYOUT == LAYOUT_MIXED);

  logic is_b, is_h, is_w;

  always_comb begin
    is_b = (size == 2'd0);
    is_h = (size == 2'd1);
    is_w = size[1];
    kind = K_PLAIN;
    phys = addr[ADDR_W-1:2];
    if (is_b && addr == A_HCTL) begin
      kind = K_HCTL;
    end else if (is_b && addr == A_PWR) begin
      kind = K_PWR;
    end else if (is_h && addr == A_XMODE) begin
      kind = K_XMODE;
      if (MIXED) phys = A_MIX[ADDR_W-1:2];
    end else if (is_h && addr == A_CMD && !MIXED) begin
      kind = K_CMD;
    end else if (is_w && addr == A_PSTAT) begin
      kind = K_PSTATE;
    end else if (is_h && addr == A_SLOT) begin
      kind = K_SLOT;
      phys = A_SIGEN[ADDR_W-1:2];
    end else if (is_h && addr == A_VER && MIXED) begin
      kind = K_VER;
    end
  end
endmodule

// File: rtl/sdx_xlate.sv
module sdx_xlate
  import sdx_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_MIXED
) (
  input  kind_e       kind,
  input  logic        write,
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  input  logic [31:0] wdata,
  input  logic [31:0] word,
  input  logic [15:0] mode_q,
  input  logic [15:0] cmd_q,
  input  logic [31:0] pstate,
  input  logic [31:0] istat,
  output logic [31:0] rdata,
  output logic        we,
  output logic [31:0] wword,
  output logic        mode_we,
  output logic        cmd_we
);
  localparam bit MIXED = (LAYOUT == LAYOUT_MIXED);

  logic [4:0]  sh;
  logic [31:0] lane_mask, lane_rd, lane_wr;

  always_comb begin
    sh = {lane, 3'b000};
    case (size)
      2'd0:    lane_mask = 32'h0000_00FF << sh;
      2'd1:    lane_mask = 32'h0000_FFFF << sh;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
    lane_rd = size[1] ? word : ((word >> sh) & (lane_mask >> sh));
    lane_wr = size[1] ? wdata : ((word & ~lane_mask) | ((wdata << sh) & lane_mask));
  end

  always_comb begin
    rdata   = '0;
    we      = 1'b0;
    wword   = word;
    mode_we = 1'b0;
    cmd_we  = 1'b0;
    case (kind)
      K_HCTL: begin
        rdata = {24'h0, hctl_unpack(word)};
        we    = write;
        wword = hctl_pack(word, wdata[7:0]);
      end
      K_PWR: rdata = PWR_READ;
      K_XMODE: begin
        if (MIXED) begin
          rdata = word & XMODE_KEEP;
          we    = write;
          wword = (word & ~XMODE_CLR) | (wdata & XMODE_KEEP);
        end else begin
          rdata   = {16'h0, mode_q};
          mode_we = write;
        end
      end
      K_CMD: begin
        rdata  = {16'h0, cmd_q};
        we     = write;
        cmd_we = write;
        wword  = {wdata[15:0], mode_q};
      end
      K_PSTATE: rdata = pstate_std(pstate);
      K_SLOT:   rdata = {31'h0, |(istat & word)};
      K_VER:    rdata = VER_READ;
      default: begin
        rdata = lane_rd;
        we    = write;
        wword = lane_wr;
      end
    endcase
  end
endmodule

// File: rtl/sd_reg_xlate.sv
module sd_reg_xlate
  import sdx_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_MIXED,
  parameter int      ADDR_W = 8,
  parameter int      DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [DW-1:0]     hw_pstate,
  input  logic [DW-1:0]     hw_istat,
  input  logic [ADDR_W-3:0] peek_idx,
  output logic [DW-1:0]     peek_data
);
  localparam int WA = ADDR_W - 2;

  state_e          st;
  kind_e           d_kind, q_kind;
  logic [WA-1:0]   d_phys, q_phys;
  logic            q_write;
  logic [1:0]      q_size, q_lane;
  logic [DW-1:0]   q_wdata;
  logic [15:0]     mode_q, cmd_q;
  logic [DW-1:0]   rf_word;
  logic [DW-1:0]   x_rdata, x_wword;
  logic            x_we, x_mode_we, x_cmd_we;
  logic            fire;

  assign req_ready = (st == ST_IDLE);
  assign fire      = req_valid && req_ready;

  sdx_decode #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_dec (
    .size (req_size),
    .addr (req_addr),
    .kind (d_kind),
    .phys (d_phys)
  );

  sdx_regfile #(.DW(DW), .AW(WA)) u_rf (
    .clk     (clk),
    .rd_en   (fire),
    .rd_addr (d_phys),
    .rd_data (rf_word),
    .wr_en   ((st == ST_EXEC) && x_we),
    .wr_addr (q_phys),
    .wr_data (x_wword),
    .pk_addr (peek_idx),
    .pk_data (peek_data)
  );

  sdx_xlate #(.LAYOUT(LAYOUT)) u_xl (
    .kind    (q_kind),
    .write   (q_write),
    .size    (q_size),
    .lane    (q_lane),
    .wdata   (q_wdata),
    .word    (rf_word),
    .mode_q  (mode_q),
    .cmd_q   (cmd_q),
    .pstate  (hw_pstate),
    .istat   (hw_istat),
    .rdata   (x_rdata),
    .we      (x_we),
    .wword   (x_wword),
    .mode_we (x_mode_we),
    .cmd_we  (x_cmd_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      q_kind    <= K_PLAIN;
      q_phys    <= '0;
      q_write   <= 1'b0;
      q_size    <= 2'd0;
      q_lane    <= 2'd0;
      q_wdata   <= '0;
      mode_q    <= '0;
      cmd_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (fire) begin
            q_kind  <= d_kind;
            q_phys  <= d_phys;
            q_write <= req_write;
            q_size  <= req_size;
            q_lane  <= req_addr[1:0];
            q_wdata <= req_wdata;
            st      <= ST_EXEC;
          end
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= q_write ? '0 : x_rdata;
          if (x_mode_we) mode_q <= q_wdata[15:0];
          if (x_cmd_we)  cmd_q  <= q_wdata[15:0];
          st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sdx_chk.sv
module sdx_chk
  import sdx_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_MIXED,
  parameter int      ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata
);
  localparam int RW = ADDR_W + 3;

  logic [RW-1:0] a1, a2;
  logic rd_pwr, rd_slot, rd_hctl, rd_ver;

  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0;
      a2 <= '0;
    end else begin
      if (req_valid && req_ready) a1 <= {req_write, req_size, req_addr};
      a2 <= a1;
    end
  end

  assign rd_pwr  = !a2[RW-1] && a2[RW-2:RW-3] == 2'd0 && a2[ADDR_W-1:0] == ADDR_W'(OFS_PWR);
  assign rd_hctl = !a2[RW-1] && a2[RW-2:RW-3] == 2'd0 && a2[ADDR_W-1:0] == ADDR_W'(OFS_HCTL);
  assign rd_slot = !a2[RW-1] && a2[RW-2:RW-3] == 2'd1 && a2[ADDR_W-1:0] == ADDR_W'(OFS_SLOT);
  assign rd_ver  = !a2[RW-1] && a2[RW-2:RW-3] == 2'd1 && a2[ADDR_W-1:0] == ADDR_W'(OFS_VER);

  p_accept_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_accept_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 rsp_valid);
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_rsp_ready_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
  p_pwr_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rd_pwr) |-> rsp_rdata == PWR_READ);
  p_slot_bool_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rd_slot) |-> rsp_rdata[31:1] == 31'h0);
  p_hctl_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rd_hctl) |-> (rsp_rdata[31:8] == 24'h0 && rsp_rdata[4:3] != 2'b01
                                && !(rsp_rdata[1] && rsp_rdata[5])));

  generate
    if (LAYOUT == LAYOUT_MIXED) begin : g_ver
      p_version_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rd_ver) |-> rsp_rdata == VER_READ);
    end
  endgenerate
endmodule

bind sd_reg_xlate sdx_chk #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_sd_reg_xlate.sv
module sim_sd_reg_xlate;
  import sdx_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'h0;
  logic [31:0] req_wdata = '0, hw_pstate = '0, hw_istat = '0;
  logic [5:0]  peek_idx = '0;
  logic        rdy0, rdy1, rv0, rv1;
  logic [31:0] rd0, rd1, pk0, pk1;

  int n_run = 0, n_fail = 0;
  logic [31:0] shadow [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_reg_xlate #(.LAYOUT(LAYOUT_COMBINED)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy0), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv0),
    .rsp_rdata(rd0), .hw_pstate(hw_pstate), .hw_istat(hw_istat), .peek_idx(peek_idx),
    .peek_data(pk0));

  sd_reg_xlate #(.LAYOUT(LAYOUT_MIXED)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy1), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv1),
    .rsp_rdata(rd1), .hw_pstate(hw_pstate), .hw_istat(hw_istat), .peek_idx(peek_idx),
    .peek_data(pk1));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    r0 = rv0 ? rd0 : 32'hDEAD_0000;
    r1 = rv1 ? rd1 : 32'hDEAD_0001;
  endtask

  task automatic peek(input int idx, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk);
    peek_idx = 6'(idx);
    @(posedge clk);
    @(negedge clk);
    v0 = pk0; v1 = pk1;
  endtask

  function automatic logic [31:0] ref_hctl_wr(input logic [31:0] w, input logic [7:0] v);
    logic [31:0] r = w;
    r[0] = v[0]; r[6] = v[6]; r[7] = v[7];
    if (v[5])      r[2:1] = 2'b10;
    else if (v[1]) r[2:1] = 2'b01;
    else           r[2:1] = 2'b00;
    r[8] = v[3]; r[9] = v[4];
    return r;
  endfunction

  function automatic logic [31:0] ref_hctl_rd(input logic [31:0] w);
    logic [31:0] r = '0;
    r[0] = w[0]; r[6] = w[6]; r[7] = w[7];
    case (w[2:1]) 2'b01: r[1] = 1'b1; 2'b10: r[5] = 1'b1; default: ; endcase
    case (w[9:8]) 2'b10: r[4] = 1'b1; 2'b11: r[4:3] = 2'b11; default: ; endcase
    return r;
  endfunction

  function automatic logic [31:0] ref_pstate(input logic [31:0] p);
    logic [31:0] r = '0;
    r[2:0] = p[2:0]; r[11:8] = p[11:8]; r[19:16] = p[19:16];
    r[23:20] = p[27:24]; r[3] = p[12];
    return r;
  endfunction

  function automatic logic [31:0] ref_rmw(input logic [31:0] w, input logic [1:0] sz,
                                          input logic [1:0] ln, input logic [31:0] d);
    logic [31:0] r = w;
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int base = (sz[1]) ? 0 : int'(ln);
    for (int b = 0; b < nb; b++) r[(base+b)*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] ref_lane(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] ln);
    logic [31:0] r = '0;
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int base = (sz[1]) ? 0 : int'(ln);
    for (int b = 0; b < nb; b++) r[b*8 +: 8] = w[(base+b)*8 +: 8];
    return r;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b, cur, e, p;
    bit ok;
    void'($urandom(32'h0000_5D31));
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state and zeroed file
    check(rdy0 && rdy1 && !rv0 && !rv1, "R1 ready/valid after reset", {rdy0, rdy1, rv0, rv1}, 4'b1100);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      peek(i, a, b);
      if (a != 0 || b != 0) ok = 1'b0;
    end
    check(ok, "R1 register file zero", a | b, 32'h0);

    // R2/R3: host control mapping with a prefilled word
    cur = 32'h0000_0C38;
    acc(1'b1, 2'd2, 8'h28, cur, a, b);
    acc(1'b1, 2'd0, 8'h28, 32'h22, a, b);
    cur = ref_hctl_wr(cur, 8'h22);
    peek(10, a, b);
    check(a == cur && b == cur && cur[2:1] == 2'b10, "R2 8-bit flag beats 4-bit", a, cur);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v = 8'($urandom());
      acc(1'b1, 2'd0, 8'h28, {24'h0, v}, a, b);
      cur = ref_hctl_wr(cur, v);
      peek(10, a, b);
      check(a == cur && b == cur, "R2 host control write", a, cur);
      acc(1'b0, 2'd0, 8'h28, 32'h0, a, b);
      e = ref_hctl_rd(cur);
      check(a == e && b == e, "R3 host control read", a, e);
    end
    foreach (cur[i]) ;
    for (int m = 0; m < 4; m++) begin
      acc(1'b1, 2'd0, 8'h28, 32'(m << 3), a, b);
      cur = ref_hctl_wr(cur, 8'(m << 3));
      acc(1'b0, 2'd0, 8'h28, 32'h0, a, b);
      e = ref_hctl_rd(cur);
      check(a == e && b == e, "R3 DMA select readback", a, e);
    end

    // R4: present state translation
    for (int k = 0; k < 10; k++) begin
      p = (k == 0) ? 32'hFFFF_FFFF : $urandom();
      @(negedge clk); hw_pstate = p;
      acc(1'b0, 2'd2, 8'h24, 32'h0, a, b);
      e = ref_pstate(p);
      check(a == e && b == e, "R4 present state", a, e);
    end

    // R5/R7: transfer mode
    acc(1'b1, 2'd2, 8'h48, 32'hFFFF_FFFF, a, b);
    shadow[18] = 32'hFFFF_FFFF;
    acc(1'b1, 2'd1, 8'h0C, 32'h0000_00C8, a, b);
    peek(3, a, b);
    check(a == 32'h0, "R5 mode write cached only", a, 32'h0);
    peek(18, a, b);
    check(b == 32'hFFFF_FFC0, "R7 mixed-control low bits", b, 32'hFFFF_FFC0);
    acc(1'b1, 2'd1, 8'h0C, 32'h0000_00FF, a, b);
    peek(18, a, b);
    check(b == 32'hFFFF_FFF7, "R7 mixed-control write", b, 32'hFFFF_FFF7);
    check(a == 32'hFFFF_FFFF, "R5 combined leaves 0x48 alone", a, 32'hFFFF_FFFF);
    acc(1'b0, 2'd1, 8'h0C, 32'h0, a, b);
    check(a == 32'h00FF, "R5 cached mode readback", a, 32'h00FF);
    check(b == 32'h0037, "R7 mixed-control readback", b, 32'h0037);

    // R6: command merge (combined), plain halfword (mixed)
    acc(1'b1, 2'd1, 8'h0E, 32'h0000_1234, a, b);
    peek(3, a, b);
    check(a == 32'h1234_00FF, "R6 merged command word", a, 32'h1234_00FF);
    check(b == 32'h1234_0000, "R11 mixed command halfword", b, 32'h1234_0000);
    acc(1'b0, 2'd1, 8'h0E, 32'h0, a, b);
    check(a == 32'h1234 && b == 32'h1234, "R6 command readback", a, 32'h1234);

    // R8: version
    acc(1'b0, 2'd1, 8'hFE, 32'h0, a, b);
    check(b == 32'h0002, "R8 mixed version", b, 32'h0002);
    check(a == 32'h0000, "R8 combined plain halfword", a, 32'h0000);

    // R9: slot interrupt summary
    acc(1'b1, 2'd2, 8'h38, 32'h0000_0110, a, b);
    for (int k = 0; k < 8; k++) begin
      p = (k == 0) ? 32'h0000_0010 : (k == 1) ? 32'hFFFF_FEEF : $urandom();
      @(negedge clk); hw_istat = p;
      acc(1'b0, 2'd1, 8'hFC, 32'h0, a, b);
      e = {31'h0, |(p & 32'h0000_0110)};
      check(a == e && b == e, "R9 slot interrupt", a, e);
    end

    // R10: power control
    peek(10, a, b); cur = a;
    acc(1'b1, 2'd0, 8'h29, 32'h0000_00FF, a, b);
    peek(10, a, b);
    check(a == cur && b == cur, "R10 power write ignored", a, cur);
    acc(1'b0, 2'd0, 8'h29, 32'h0, a, b);
    check(a == 32'h0D && b == 32'h0D, "R10 power read", a, 32'h0D);

    // R11: random plain accesses with lane merge
    for (int k = 0; k < 40; k++) begin
      int sel = int'($urandom() % 6);
      int idx = (sel < 2) ? 16 + sel : 18 + sel;
      logic [1:0] sz = 2'($urandom() % 3);
      logic [1:0] ln = (sz == 2'd0) ? 2'($urandom()) : (sz == 2'd1) ? {1'($urandom()), 1'b0} : 2'd0;
      logic [31:0] d = $urandom();
      if ($urandom() % 2 == 0) begin
        acc(1'b1, sz, 8'({idx[5:0], ln}), d, a, b);
        shadow[idx] = ref_rmw(shadow[idx], sz, ln, d);
        peek(idx, a, b);
        check(a == shadow[idx] && b == shadow[idx], "R11 lane write", a, shadow[idx]);
      end else begin
        acc(1'b0, sz, 8'({idx[5:0], ln}), 32'h0, a, b);
        e = ref_lane(shadow[idx], sz, ln);
        check(a == e && b == e, "R11 lane read", a, e);
      end
    end

    // R12: back-to-back write then read of the same word
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 8'h41; req_wdata = 32'h5A;
    @(posedge clk);
    @(negedge clk);
    check(!rdy0 && !rdy1 && !rv0, "R12 busy after accept", {rdy0, rdy1, rv0}, 3'b000);
    req_write = 1'b0; req_size = 2'd2; req_addr = 8'h40;
    @(posedge clk);
    @(negedge clk);
    check(rv0 && rv1 && rdy0 && rdy1, "R12 response with ready", {rv0, rv1, rdy0, rdy1}, 4'b1111);
    check(rd0 == 32'h0, "R12 write response zero", rd0, 32'h0);
    shadow[16] = ref_rmw(shadow[16], 2'd0, 2'd1, 32'h5A);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!rv0 && !rdy0, "R12 second accept busy", {rv0, rdy0}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check(rv0 && rv1 && rd0 == shadow[16] && rd1 == shadow[16], "R12 back-to-back read", rd0, shadow[16]);
    @(posedge clk);
    @(negedge clk);
    check(!rv0 && !rv1, "R12 single pulse", {rv0, rv1}, 2'b00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule